// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a slave on a two-wire I2C-compatible bus. It lets a host controller read and write a small bank of 8-bit configuration registers inside the chip. The SCL and SDA pins are sampled through synchronisers into a faster system clock. SDA is never driven high: the block only asserts an open-drain pull-down enable. Start and stop conditions, the 7-bit address match, ACK/NACK generation, a subaddress pointer with auto-increment, and the register bank itself all live inside it. The register contents are brought out in parallel so that the rest of the chip can use them.

A write transfer has three parts. It begins with the device address and a direction bit of 0, then one subaddress byte, then any number of data bytes. Each data byte lands at the pointer, and the pointer then steps up by one. To read, the host first writes the subaddress and then issues a repeated start with the direction bit set to 1. Data then comes out from the stored pointer, one register after another, for as long as the host acknowledges each byte.

The upper six address bits are fixed at 110101. The lowest address bit comes from a strap pin. There is no streaming interface at the edge of the block: the bus pins, the strap and the register outputs are all plain signals. The system clock must run at least 8 times the SCL rate.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset the pull-down enable is released, and register i holds RST_BASE + i (0xA0 + i with the default parameters).
- R2: An address byte whose upper seven bits equal {110101, addr_sel} is acknowledged. Any other address is not acknowledged, and the block then leaves SDA released until the next start condition.
- R3: In a write, the byte after the address byte sets the pointer. Each following data byte is stored at the pointer and acknowledged, and the pointer then increases by one.
- R4: A subaddress byte with a value of NUM_REGS (16) or more is not acknowledged. The block returns to idle and no register changes.
- R5: A write data byte that arrives when the pointer has passed the top register (15) is neither stored nor acknowledged. The block returns to idle, so any further bytes are also not acknowledged.
- R6: Address bit 0 selects the direction: 0 means the host writes, 1 means the host reads. A read that follows a repeated start returns the register at the stored pointer, MSB first. Each byte the host acknowledges advances the pointer by one.
- R7: Once a read has moved past the top register, every further byte returns the contents of the top register.
- R8: After the host answers a read byte with a NACK, the block keeps SDA released until the next start or stop.
- R9: A start condition at any point restarts address reception. A stop condition at any point returns the block to idle. A byte cut short by either one writes nothing.
- R10: The pull-down enable is only ever asserted while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| addr_sel | input | 1 | Strap value for address bit 0 |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_regs | output | 8*NUM_REGS | Register bank contents, register i at bits [8i+7:8i] |

## Verification
The hardest state to reach from the pins is the boundary past the top register. For a write, it takes a burst of data bytes that starts two registers below the top and runs past it. For a read, it takes a repeated start after a subaddress near the top, followed by acknowledged reads that continue beyond the last register. The stimulus builds both transfers bit by bit on a modelled open-drain bus. It also cuts a byte in half with a stop, and another with a start, to reach the abort paths. All expected values come from a register model inside the bench.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int         NUM_REGS = 16,
  parameter logic [7:0] RST_BASE = 8'hA0,
  localparam int        AW       = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [7:0]            rd_data,
  output logic [8*NUM_REGS-1:0] regs_flat
);
  logic [7:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= RST_BASE + 8'(g);
      else if (wr_en && wr_addr == AW'(g))
        regs[g] <= wr_data;
    end
    assign regs_flat[8*g +: 8] = regs[g];
  end

  assign rd_data = regs[rd_addr];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_slave_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter logic [5:0] DEV_ADDR_HI = 6'b110101,
  localparam int        AW          = $clog2(NUM_REGS),
  localparam int        PW          = $clog2(NUM_REGS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_sel,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe,
  output slv_state_t    state,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] TOP_P = PW'(NUM_REGS - 1);
  localparam logic [PW-1:0] END_P = PW'(NUM_REGS);

  logic [7:0] shreg;
  logic [7:0] txreg;
  logic [3:0] bitcnt;
  logic       rw_q;
  logic       mack;
  logic [PW-1:0] ptr_inc;

  assign ptr_inc = (ptr < END_P) ? ptr + 1'b1 : ptr;
  assign rd_addr = (ptr >= END_P) ? AW'(TOP_P) : AW'(ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      txreg   <= '0;
      bitcnt  <= '0;
      rw_q    <= 1'b0;
      mack    <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == {DEV_ADDR_HI, addr_sel}) begin
                  rw_q   <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_SUB) begin
                if ({1'b0, shreg} < 9'(NUM_REGS)) begin
                  ptr    <= PW'(shreg);
                  sda_oe <= 1'b1;
                  state  <= ST_SUB_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                if (ptr < END_P) begin
                  wr_en   <= 1'b1;
                  wr_addr <= AW'(ptr);
                  wr_data <= shreg;
                  ptr     <= ptr_inc;
                  sda_oe  <= 1'b1;
                  state   <= ST_WDATA_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw_q) begin
                txreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                ptr    <= ptr_inc;
                state  <= ST_RACK;
              end else begin
                txreg  <= {txreg[6:0], 1'b0};
                sda_oe <= ~txreg[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (mack) begin
                txreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= ST_RDATA;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slave_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter logic [7:0] RST_BASE    = 8'hA0,
  parameter logic [5:0] DEV_ADDR_HI = 6'b110101,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(NUM_REGS),
  localparam int        PW          = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  addr_sel,
  output logic                  sda_oe,
  output logic [8*NUM_REGS-1:0] cfg_regs
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;
  slv_state_t    fsm_state;
  logic [PW-1:0] fsm_ptr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slave_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR_HI(DEV_ADDR_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_oe(sda_oe), .state(fsm_state), .ptr(fsm_ptr)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .RST_BASE(RST_BASE)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .regs_flat(cfg_regs)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk
  import i2c_slave_pkg::*;
#(
  parameter int  NUM_REGS = 16,
  localparam int PW       = $clog2(NUM_REGS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_lvl,
  input logic          start_det,
  input logic          stop_det,
  input logic          sda_oe,
  input logic          wr_en,
  input slv_state_t    state,
  input logic [PW-1:0] ptr
);
  // R10
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_lvl));
  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> state == ST_ADDR);
  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> state == ST_IDLE);
  // R2
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_WAIT) |-> !sda_oe);
  // R3
  write_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (state == ST_WDATA_ACK && sda_oe));
  // R7
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(NUM_REGS));
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .wr_en(wr_en),
  .state(fsm_state), .ptr(fsm_ptr)
);

// File: tb/i2c_reg_slave_test.sv
module i2c_reg_slave_test;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic addr_sel = 1'b0;
  logic sda_oe;
  logic [8*NREG-1:0] cfg_regs;
  logic sda_bus;

  int checks = 0;
  int fails = 0;
  int oe_viol = 0;
  logic [7:0] model [NREG];

  assign sda_bus = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  i2c_reg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .cfg_regs(cfg_regs)
  );

  // sub, data, sub_ack expected, data_ack expected
  localparam logic [17:0] VEC [6] = '{
    {8'h00, 8'h5A, 2'b11},
    {8'h07, 8'h3C, 2'b11},
    {8'h0F, 8'hE1, 2'b11},
    {8'h10, 8'h99, 2'b00},
    {8'hFF, 8'h11, 2'b00},
    {8'h0A, 8'h00, 2'b11}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wt(5);
    scl = 1'b1; wt(10);
    m_sda = 1'b0; wt(10);
    scl = 1'b0; wt(10);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wt(10);
    scl = 1'b1; wt(10);
    m_sda = 1'b1; wt(20);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wt(10);
    scl = 1'b1; wt(20);
    scl = 1'b0; wt(10);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wt(10);
    scl = 1'b1; wt(10);
    b = sda_bus; wt(10);
    scl = 1'b0; wt(10);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~give_ack);
  endtask

  task automatic check_bank(input string tag);
    bit ok = 1'b1;
    int bad = 0;
    for (int i = 0; i < NREG; i++)
      if (cfg_regs[8*i +: 8] !== model[i]) begin
        ok = 1'b0;
        bad = i;
      end
    chk(ok, tag, int'(cfg_regs[8*bad +: 8]), int'(model[bad]));
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // R10 monitor: enable must never rise while SCL is high
  always @(posedge clk) begin
    if (rst_n && sda_oe && !$past(sda_oe) && scl) oe_viol++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic a, a2, a3;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) model[i] = 8'hA0 + 8'(i);
    wt(4);
    rst_n = 1'b1;
    wt(4);

    // R1 reset state
    chk(sda_oe == 1'b0, "R1 oe after reset", int'(sda_oe), 0);
    check_bank("R1 reset register values");

    // Table-driven single writes: R3 and R4
    for (int v = 0; v < 6; v++) begin
      bus_start();
      write_byte(8'hD4, a);
      chk(a == 1'b1, "R2 address ack", int'(a), 1);
      write_byte(VEC[v][17:10], a2);
      chk(a2 == VEC[v][1], "R4 subaddress ack", int'(a2), int'(VEC[v][1]));
      write_byte(VEC[v][9:2], a3);
      chk(a3 == VEC[v][0], "R3 data ack", int'(a3), int'(VEC[v][0]));
      bus_stop();
      if (VEC[v][0]) model[VEC[v][17:10]] = VEC[v][9:2];
      check_bank("R3 R4 bank after write");
    end

    // R2 mismatched address with strap low
    bus_start();
    write_byte(8'hD6, a);
    chk(a == 1'b0, "R2 wrong address nack", int'(a), 0);
    write_byte(8'h00, a2);
    chk(a2 == 1'b0, "R2 bus stays released", int'(a2), 0);
    bus_stop();

    // R2 strap high selects the other address
    addr_sel = 1'b1;
    wt(4);
    bus_start();
    write_byte(8'hD6, a);
    chk(a == 1'b1, "R2 strap address ack", int'(a), 1);
    write_byte(8'h05, a2);
    write_byte(8'h77, a3);
    bus_stop();
    model[5] = 8'h77;
    check_bank("R2 strap write stored");
    bus_start();
    write_byte(8'hD4, a);
    chk(a == 1'b0, "R2 old address refused", int'(a), 0);
    bus_stop();
    addr_sel = 1'b0;
    wt(4);

    // R5 write burst past the top register
    bus_start();
    write_byte(8'hD4, a);
    write_byte(8'h0E, a);
    write_byte(8'hB1, a);
    chk(a == 1'b1, "R5 byte to reg 14 ack", int'(a), 1);
    write_byte(8'hB2, a);
    chk(a == 1'b1, "R5 byte to reg 15 ack", int'(a), 1);
    write_byte(8'hB3, a);
    chk(a == 1'b0, "R5 overrun byte nack", int'(a), 0);
    write_byte(8'hB4, a);
    chk(a == 1'b0, "R5 idle after overrun", int'(a), 0);
    bus_stop();
    model[14] = 8'hB1;
    model[15] = 8'hB2;
    check_bank("R5 overrun not stored");

    // R6 R7 R8 read across the top register
    bus_start();
    write_byte(8'hD4, a);
    write_byte(8'h0E, a);
    bus_start();
    write_byte(8'hD5, a);
    chk(a == 1'b1, "R6 read address ack", int'(a), 1);
    read_byte(1'b1, d);
    chk(d == model[14], "R6 first read byte", int'(d), int'(model[14]));
    read_byte(1'b1, d);
    chk(d == model[15], "R6 incremented read", int'(d), int'(model[15]));
    read_byte(1'b1, d);
    chk(d == model[15], "R7 repeat top register", int'(d), int'(model[15]));
    read_byte(1'b0, d);
    chk(d == model[15], "R7 repeat top again", int'(d), int'(model[15]));
    read_byte(1'b0, d);
    chk(d == 8'hFF, "R8 released after nack", int'(d), 8'hFF);
    bus_stop();

    // R6 read from a low pointer
    bus_start();
    write_byte(8'hD4, a);
    write_byte(8'h03, a);
    bus_start();
    write_byte(8'hD5, a);
    read_byte(1'b1, d);
    chk(d == model[3], "R6 read reg 3", int'(d), int'(model[3]));
    read_byte(1'b0, d);
    chk(d == model[4], "R6 read reg 4", int'(d), int'(model[4]));
    bus_stop();

    // R9 stop in the middle of a data byte
    bus_start();
    write_byte(8'hD4, a);
    write_byte(8'h02, a);
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    bus_stop();
    chk(sda_oe == 1'b0, "R9 released after stop", int'(sda_oe), 0);
    check_bank("R9 partial byte not written");

    // R9 start in the middle of a byte restarts addressing
    bus_start();
    write_byte(8'hD4, a);
    write_byte(8'h09, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start();
    write_byte(8'hD4, a);
    chk(a == 1'b1, "R9 address after restart", int'(a), 1);
    write_byte(8'h09, a);
    write_byte(8'h42, a);
    bus_stop();
    model[9] = 8'h42;
    check_bank("R9 write after restart");

    chk(oe_viol == 0, "R10 enable rose with SCL high", oe_viol, 0);
    finish_run();
  end
endmodule